// File: doc/BRIEF.md
# Power-Trace Correlation Sum Accumulator

This block gathers the running sums that a host needs to judge one key-byte guess in a correlation power attack on the last round of a 128-bit block cipher. Each encryption contributes one ciphertext byte and one power sample, which is the measurement taken at a single chosen time index. Under the configured key-byte guess, the block predicts the power drawn at the substitution boundary. The prediction is the number of bits that change between the ciphertext byte and the register content just before the substitution box. That content is the inverse substitution of the ciphertext byte XOR the guess.

The block accepts one sample per clock. It keeps the count and the sums of x, y, x·y, x² and y², where x is the measured sample and y is the predicted bit-flip count. On a finish strobe it forms three terms of the sample Pearson coefficient: the covariance numerator and the two variance terms. Software takes the square root and does the division. To sweep all 256 guesses, the host clears the block, replays the traces for each guess, and keeps the guess with the largest correlation.

Top module: `cpa_hd_accum`

## Requirements
- R1: After reset, `numer`, `var_x` and `var_y` are zero, `n_count` is 0, and `res_valid` and `overflow` are low.
- R2: For each accepted sample, the hypothesis is y = popcount(ct XOR InvSbox(ct XOR key)). InvSbox is the inverse of the standard 128-bit block cipher substitution box, so InvSbox(0x63)=0x00 and InvSbox(0x16)=0xFF. Rising and falling bits count alike, and y lies in 0..8.
- R3: Every cycle with `smp_valid` high adds one unsigned 12-bit sample, and `n_count` rises by one per accepted sample. There are no idle cycles between samples.
- R4: `numer` equals n·Σxy − Σx·Σy as a signed 64-bit value.
- R5: `var_x` equals n·Σx² − (Σx)² as a signed 64-bit value.
- R6: `var_y` equals n·Σy² − (Σy)² as a signed 64-bit value.
- R7: Suppose `finish` is sampled high at clock edge E0. The result outputs then update, and `res_valid` rises, at the second edge after E0. A sample offered in the same cycle as `finish` is included.
- R8: `n_count` saturates at 65535. A valid sample that arrives once the count is full is not added to any sum, and it sets `overflow`, which stays high until a clear.
- R9: `clr` zeroes the count, every sum and `overflow` in one cycle. The sample offered in the clear cycle is dropped, and so is the sample offered in the cycle just before it. A pending finish is cancelled.
- R10: The key guess is sampled together with each sample, so a change of guess applies from the next accepted sample on.
- R11: `res_valid` is a one-cycle pulse. The result outputs keep their values until the next finish produces new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Zero count, sums and overflow |
| key_guess | input | 8 | Last-round key-byte hypothesis |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_ct | input | 8 | Ciphertext byte of the encryption |
| smp_x | input | X_W (12) | Unsigned power sample |
| finish | input | 1 | Request the correlation terms |
| res_valid | output | 1 | One-cycle pulse when results update |
| numer | output | 64 | Signed covariance numerator |
| var_x | output | 64 | Signed variance term of samples |
| var_y | output | 64 | Signed variance term of hypotheses |
| n_count | output | N_W (16) | Accepted sample count |
| overflow | output | 1 | Sample arrived after the count was full |

## Verification
A vector table with mixed key guesses, ciphertext bytes and sample values is replayed twice: once with its own guesses and once with a single forced guess. The two runs differ only through the hypothesis path, which separates a wrong inverse-substitution or key XOR from a wrong sum. Hand-picked pairs with flip counts of 8 and 0, and of 4 and 3, give fixed variance and numerator values. These pairs confirm the inverse substitution itself and the extremes of the range. A constant-sample run must produce zero covariance and zero x-variance, which exposes cross-wired sums. The saturation run offers extra samples with a different value once the count is full: if any of them were summed, the x-variance would become nonzero.

// File: rtl/cpa_pkg.sv
`timescale 1ns/1ps
package cpa_pkg;

  localparam int BYTE_W = 8;
  localparam int HD_W   = 4;
  localparam int RES_W  = 64;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (0 maps to 0)
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] r;
    logic [BYTE_W-1:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  // inverse substitution: undo the affine map, then invert
  function automatic logic [BYTE_W-1:0] inv_sub(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r1, r3, r6;
    r1 = {b[6:0], b[7]};
    r3 = {b[4:0], b[7:5]};
    r6 = {b[1:0], b[7:2]};
    return gf_inv(r1 ^ r3 ^ r6 ^ 8'h05);
  endfunction

  function automatic logic [HD_W-1:0] flip_count(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
    logic [HD_W-1:0] c;
    logic [BYTE_W-1:0] d;
    d = a ^ b;
    c = '0;
    for (int i = 0; i < BYTE_W; i++) c = c + HD_W'(d[i]);
    return c;
  endfunction

  // n*s_ab - s_a*s_b
  function automatic logic signed [RES_W-1:0] pearson_term(
      input logic signed [RES_W-1:0] n,
      input logic signed [RES_W-1:0] s_ab,
      input logic signed [RES_W-1:0] s_a,
      input logic signed [RES_W-1:0] s_b);
    return n * s_ab - s_a * s_b;
  endfunction

endpackage

// File: rtl/cpa_hyp_stage.sv
`timescale 1ns/1ps
module cpa_hyp_stage import cpa_pkg::*; #(
  parameter int X_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_ct,
  input  logic [BYTE_W-1:0] in_key,
  input  logic [X_W-1:0]    in_x,
  output logic              s1_valid,
  output logic [X_W-1:0]    s1_x,
  output logic [HD_W-1:0]   s1_y
);

  logic [BYTE_W-1:0] pre_sub;
  logic [HD_W-1:0]   hd_now;

  assign pre_sub = inv_sub(in_ct ^ in_key);
  assign hd_now  = flip_count(pre_sub, in_ct);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
    end else begin
      s1_valid <= in_valid & ~clr;
      if (in_valid) begin
        s1_x <= in_x;
        s1_y <= hd_now;
      end
    end
  end

  // R2
  hyp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (s1_y <= HD_W'(8)));

  // R9
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !s1_valid);

endmodule

// File: rtl/cpa_sum_bank.sv
`timescale 1ns/1ps
module cpa_sum_bank import cpa_pkg::*; #(
  parameter  int X_W    = 12,
  parameter  int MAX_N  = 65535,
  localparam int N_W    = $clog2(MAX_N + 1),
  localparam int Y_W    = HD_W,
  localparam int SX_W   = X_W + N_W,
  localparam int SY_W   = Y_W + N_W,
  localparam int SXX_W  = 2 * X_W + N_W,
  localparam int SYY_W  = 2 * Y_W + N_W,
  localparam int SXY_W  = X_W + Y_W + N_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             s1_valid,
  input  logic [X_W-1:0]   s1_x,
  input  logic [Y_W-1:0]   s1_y,
  output logic [N_W-1:0]   n_cnt,
  output logic [SX_W-1:0]  sx,
  output logic [SY_W-1:0]  sy,
  output logic [SXX_W-1:0] sxx,
  output logic [SYY_W-1:0] syy,
  output logic [SXY_W-1:0] sxy,
  output logic             overflow
);

  logic at_cap;
  logic acc_en;
  logic ovf_evt;
  logic [2*X_W-1:0]   x_sq;
  logic [2*Y_W-1:0]   y_sq;
  logic [X_W+Y_W-1:0] xy;

  assign at_cap  = (n_cnt == N_W'(MAX_N));
  assign acc_en  = s1_valid & ~at_cap & ~clr;
  assign ovf_evt = s1_valid & at_cap & ~clr;

  assign x_sq = (2*X_W)'(s1_x) * (2*X_W)'(s1_x);
  assign y_sq = (2*Y_W)'(s1_y) * (2*Y_W)'(s1_y);
  assign xy   = (X_W+Y_W)'(s1_x) * (X_W+Y_W)'(s1_y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt    <= '0;
      sx       <= '0;
      sy       <= '0;
      sxx      <= '0;
      syy      <= '0;
      sxy      <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      n_cnt    <= '0;
      sx       <= '0;
      sy       <= '0;
      sxx      <= '0;
      syy      <= '0;
      sxy      <= '0;
      overflow <= 1'b0;
    end else begin
      if (acc_en) begin
        n_cnt <= n_cnt + 1'b1;
        sx    <= sx  + SX_W'(s1_x);
        sy    <= sy  + SY_W'(s1_y);
        sxx   <= sxx + SXX_W'(x_sq);
        syy   <= syy + SYY_W'(y_sq);
        sxy   <= sxy + SXY_W'(xy);
      end
      if (ovf_evt) overflow <= 1'b1;
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !clr && n_cnt != N_W'(MAX_N)) |=> (n_cnt == $past(n_cnt) + 1'b1));

  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(n_cnt) == N_W'(MAX_N)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt) |=> $stable(sx) && $stable(sxx));

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (n_cnt == '0) && (sx == '0) && (syy == '0) && !overflow);

endmodule

// File: rtl/cpa_corr_terms.sv
`timescale 1ns/1ps
module cpa_corr_terms import cpa_pkg::*; #(
  parameter  int X_W    = 12,
  parameter  int MAX_N  = 65535,
  localparam int N_W    = $clog2(MAX_N + 1),
  localparam int Y_W    = HD_W,
  localparam int SX_W   = X_W + N_W,
  localparam int SY_W   = Y_W + N_W,
  localparam int SXX_W  = 2 * X_W + N_W,
  localparam int SYY_W  = 2 * Y_W + N_W,
  localparam int SXY_W  = X_W + Y_W + N_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [N_W-1:0]          n_cnt,
  input  logic [SX_W-1:0]         sx,
  input  logic [SY_W-1:0]         sy,
  input  logic [SXX_W-1:0]        sxx,
  input  logic [SYY_W-1:0]        syy,
  input  logic [SXY_W-1:0]        sxy,
  output logic                    res_valid,
  output logic signed [RES_W-1:0] numer,
  output logic signed [RES_W-1:0] var_x,
  output logic signed [RES_W-1:0] var_y
);

  logic signed [RES_W-1:0] n_e, sx_e, sy_e, sxx_e, syy_e, sxy_e;

  assign n_e   = RES_W'(n_cnt);
  assign sx_e  = RES_W'(sx);
  assign sy_e  = RES_W'(sy);
  assign sxx_e = RES_W'(sxx);
  assign syy_e = RES_W'(syy);
  assign sxy_e = RES_W'(sxy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      numer     <= '0;
      var_x     <= '0;
      var_y     <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        numer <= pearson_term(n_e, sxy_e, sx_e, sy_e);
        var_x <= pearson_term(n_e, sxx_e, sx_e, sx_e);
        var_y <= pearson_term(n_e, syy_e, sy_e, sy_e);
      end
    end
  end

  // R5
  varx_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !var_x[RES_W-1]);

  // R6
  vary_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !var_y[RES_W-1]);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(numer) && $stable(var_x) && $stable(var_y));

  // R11
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !fire) |=> !res_valid);

endmodule

// File: rtl/cpa_hd_accum.sv
`timescale 1ns/1ps
module cpa_hd_accum import cpa_pkg::*; #(
  parameter  int X_W   = 12,
  parameter  int MAX_N = 65535,
  localparam int N_W   = $clog2(MAX_N + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [BYTE_W-1:0]       key_guess,
  input  logic                    smp_valid,
  input  logic [BYTE_W-1:0]       smp_ct,
  input  logic [X_W-1:0]          smp_x,
  input  logic                    finish,
  output logic                    res_valid,
  output logic signed [RES_W-1:0] numer,
  output logic signed [RES_W-1:0] var_x,
  output logic signed [RES_W-1:0] var_y,
  output logic [N_W-1:0]          n_count,
  output logic                    overflow
);

  localparam int Y_W   = HD_W;
  localparam int SX_W  = X_W + N_W;
  localparam int SY_W  = Y_W + N_W;
  localparam int SXX_W = 2 * X_W + N_W;
  localparam int SYY_W = 2 * Y_W + N_W;
  localparam int SXY_W = X_W + Y_W + N_W;

  logic             s1_valid;
  logic [X_W-1:0]   s1_x;
  logic [Y_W-1:0]   s1_y;
  logic [SX_W-1:0]  sx;
  logic [SY_W-1:0]  sy;
  logic [SXX_W-1:0] sxx;
  logic [SYY_W-1:0] syy;
  logic [SXY_W-1:0] sxy;
  logic             fin_q1, fin_q2;
  logic             fire;

  cpa_hyp_stage #(.X_W(X_W)) u_hyp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (smp_valid),
    .in_ct    (smp_ct),
    .in_key   (key_guess),
    .in_x     (smp_x),
    .s1_valid (s1_valid),
    .s1_x     (s1_x),
    .s1_y     (s1_y)
  );

  cpa_sum_bank #(.X_W(X_W), .MAX_N(MAX_N)) u_sums (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .s1_valid (s1_valid),
    .s1_x     (s1_x),
    .s1_y     (s1_y),
    .n_cnt    (n_count),
    .sx       (sx),
    .sy       (sy),
    .sxx      (sxx),
    .syy      (syy),
    .sxy      (sxy),
    .overflow (overflow)
  );

  // finish travels two flops so the last sample is already summed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q1 <= 1'b0;
      fin_q2 <= 1'b0;
    end else begin
      fin_q1 <= finish & ~clr;
      fin_q2 <= fin_q1 & ~clr;
    end
  end

  assign fire = fin_q2 & ~clr;

  cpa_corr_terms #(.X_W(X_W), .MAX_N(MAX_N)) u_terms (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .n_cnt     (n_count),
    .sx        (sx),
    .sy        (sy),
    .sxx       (sxx),
    .syy       (syy),
    .sxy       (sxy),
    .res_valid (res_valid),
    .numer     (numer),
    .var_x     (var_x),
    .var_y     (var_y)
  );

  // R7
  res_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(finish, 3));

  // R7
  fire_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);

endmodule

// File: tb/cpa_hd_accum_bench.sv
`timescale 1ns/1ps
module cpa_hd_accum_bench;

  localparam int X_W   = 12;
  localparam int MAX_N = 65535;
  localparam int N_W   = $clog2(MAX_N + 1);
  localparam int NVEC  = 16;

  // {key[31:24], ct[23:16], 4'h0, x[11:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h3CA107F3, 32'h00630010, 32'h16000FFF, 32'h7E2B0123,
    32'hD4D40A5A, 32'h11FF0001, 32'h5A3C0800, 32'hC3960444,
    32'h00000333, 32'hFF0105B7, 32'h8E4D0C0C, 32'h27E9099A,
    32'h6B6B0001, 32'hA0180E0E, 32'h9D720678, 32'h44BE0ABC
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [7:0] key_guess = '0;
  logic smp_valid = 1'b0;
  logic [7:0] smp_ct = '0;
  logic [X_W-1:0] smp_x = '0;
  logic finish = 1'b0;
  logic res_valid;
  logic signed [63:0] numer, var_x, var_y;
  logic [N_W-1:0] n_count;
  logic overflow;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint mn, msx, msy, msxx, msyy, msxy;
  logic [7:0] isb [256];

  always #2 clk = ~clk;

  cpa_hd_accum u_cpa_hd_accum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .key_guess(key_guess),
    .smp_valid(smp_valid), .smp_ct(smp_ct), .smp_x(smp_x), .finish(finish),
    .res_valid(res_valid), .numer(numer), .var_x(var_x), .var_y(var_y),
    .n_count(n_count), .overflow(overflow)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] t = b;
    for (int i = 0; i < 8; i++) begin
      if (a[i]) r ^= t;
      t = t[7] ? ((t << 1) ^ 8'h1b) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] v);
    logic [7:0] s = 8'h00;
    logic [7:0] o;
    for (int t = 1; t < 256; t++)
      if (m_mul(v, 8'(t)) == 8'h01) s = 8'(t);
    o = s ^ {s[6:0], s[7]} ^ {s[5:0], s[7:6]} ^ {s[4:0], s[7:5]} ^ {s[3:0], s[7:4]} ^ 8'h63;
    return o;
  endfunction

  function automatic longint model_y(input logic [7:0] k, input logic [7:0] c);
    return longint'($countones(c ^ isb[c ^ k]));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    mn = 0; msx = 0; msy = 0; msxx = 0; msyy = 0; msxy = 0;
  endtask

  task automatic model_add(input logic [7:0] k, input logic [7:0] c, input logic [X_W-1:0] x);
    longint y = model_y(k, c);
    longint xv = longint'(x);
    mn++; msx += xv; msy += y; msxx += xv * xv; msyy += y * y; msxy += xv * y;
  endtask

  task automatic send(input logic [7:0] k, input logic [7:0] c, input logic [X_W-1:0] x);
    key_guess = k; smp_ct = c; smp_x = x; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
  endtask

  task automatic do_finish();
    finish = 1'b1;
    @(negedge clk);
    finish = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_model(input string tag);
    chk({tag, " R7 res_valid"}, longint'(res_valid), 1);
    chk({tag, " R3 n_count"}, longint'(n_count), mn);
    chk({tag, " R4 numer"}, numer, mn * msxy - msx * msy);
    chk({tag, " R5 var_x"}, var_x, mn * msxx - msx * msx);
    chk({tag, " R6 var_y"}, var_y, mn * msyy - msy * msy);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 256; v++) isb[m_sbox(8'(v))] = 8'(v);
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 numer", numer, 0);
    chk("R1 var_x", var_x, 0);
    chk("R1 var_y", var_y, 0);
    chk("R1 n_count", longint'(n_count), 0);
    chk("R1 res_valid", longint'(res_valid), 0);
    chk("R1 overflow", longint'(overflow), 0);

    // R2/R10: flip counts 8 (key 16, ct 00) and 0 (key 63, ct 00); second sent with finish (R7)
    send(8'h16, 8'h00, 12'd100);
    key_guess = 8'h63; smp_ct = 8'h00; smp_x = 12'd40; smp_valid = 1'b1; finish = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; finish = 1'b0;
    @(negedge clk);
    chk("R7 res_valid low after one edge", longint'(res_valid), 0);
    @(negedge clk);
    chk("R7 res_valid high after two edges", longint'(res_valid), 1);
    chk("R2 var_y for flips 8 and 0", var_y, 64);
    chk("R10 numer with per-sample guess", numer, 480);
    chk("R5 var_x pair", var_x, 3600);
    @(negedge clk);
    chk("R11 res_valid pulse ends", longint'(res_valid), 0);
    chk("R11 numer held", numer, 480);

    // R2: InvSbox(63)=00 -> 4 flips, InvSbox(00)=52 -> 3 flips
    do_clear();
    send(8'h00, 8'h63, 12'd7);
    send(8'h00, 8'h00, 12'd7);
    do_finish();
    chk("R2 var_y for flips 4 and 3", var_y, 1);
    chk("R2 numer constant x", numer, 0);

    // table walk with its own guesses
    do_clear();
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][31:24], VEC[i][23:16], VEC[i][11:0]);
      model_add(VEC[i][31:24], VEC[i][23:16], VEC[i][11:0]);
    end
    do_finish();
    check_model("table");

    // same table, one forced guess
    do_clear();
    for (int i = 0; i < NVEC; i++) begin
      send(8'h5C, VEC[i][23:16], VEC[i][11:0]);
      model_add(8'h5C, VEC[i][23:16], VEC[i][11:0]);
    end
    do_finish();
    check_model("R10 forced guess");

    // constant sample, varying ciphertext
    do_clear();
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][31:24], VEC[i][23:16], 12'd1234);
      model_add(VEC[i][31:24], VEC[i][23:16], 12'd1234);
    end
    do_finish();
    check_model("constant x");
    chk("R5 constant x var_x zero", var_x, 0);

    // R9: A, B before clear and C with clear are dropped
    do_clear();
    send(8'h11, 8'h22, 12'd900);
    send(8'h33, 8'h44, 12'd800);
    key_guess = 8'h55; smp_ct = 8'h66; smp_x = 12'd700; smp_valid = 1'b1; clr = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; clr = 1'b0;
    model_clear();
    chk("R9 count after clear", longint'(n_count), 0);
    send(8'h3C, 8'hA1, 12'd2033);
    model_add(8'h3C, 8'hA1, 12'd2033);
    send(8'hC3, 8'h96, 12'd17);
    model_add(8'hC3, 8'h96, 12'd17);
    do_finish();
    check_model("R9 after clear");

    // R8 saturation
    do_clear();
    for (int i = 0; i < MAX_N; i++) send(8'h00, 8'h63, 12'hFFF);
    @(negedge clk);
    chk("R8 count at cap", longint'(n_count), longint'(MAX_N));
    chk("R8 no overflow at cap", longint'(overflow), 0);
    send(8'h00, 8'h63, 12'd0);
    send(8'h00, 8'h63, 12'd0);
    send(8'h00, 8'h00, 12'd0);
    @(negedge clk);
    chk("R8 overflow set", longint'(overflow), 1);
    chk("R8 count held", longint'(n_count), longint'(MAX_N));
    do_finish();
    chk("R8 var_x ignores extra samples", var_x, 0);
    chk("R8 numer ignores extra samples", numer, 0);
    chk("R8 var_y ignores extra samples", var_y, 0);
    chk("R8 overflow sticky", longint'(overflow), 1);
    do_clear();
    chk("R9 overflow cleared", longint'(overflow), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule